// File: doc/BRIEF.md
# Prescaled Multi-Channel PWM Generator

This block drives several independent pulse-width modulated outputs from a single fixed reference clock. Each channel has three settings: a 4-bit frequency code that selects how many reference cycles make up one time quantum, a 10-bit high-time value counted in those quanta, and an enable bit. Every period lasts exactly 1024 quanta. The frequency code therefore moves only the length of the quantum, from 32 reference cycles (code 0) down to 17 (code 15). With a 9.6 MHz reference this spans roughly 293 Hz to 551 Hz.

Software programs the channels through a plain byte-wide synchronous register port and can read every setting back. New settings and enable changes wait for the end of the running period, so a pulse is never cut short. A channel that is switched on from the off state begins a fresh period at once, with its output high. A zero duty cycle has no encoding; software gets a constantly low output by clearing the channel's enable bit.

Top module: `pwm_multi`

## Requirements
- R1: One time quantum lasts (32 - F) reference clock cycles, where F is the channel's 4-bit frequency code (0..15).
- R2: Every period of an enabled channel is exactly 1024 quanta long, measured between consecutive rising edges.
- R3: The output is high for (S + 1) quanta at the start of each period, where S is the stored 10-bit duty field. S = 0 gives one quantum high, and S = 1023 keeps the output high for the whole period.
- R4: Channel n has a lower byte at address 2n that holds duty bits [7:0]. Its upper byte at address 2n+1 holds duty bits [9:8] in bits [1:0] and the frequency code in bits [7:4]. The enable register at address 2*N_CH (6 by default) enables channel n through bit n.
- R5: Register reads return the stored contents. Bits [3:2] of an upper byte read as 0, enable bits at or above N_CH read as 0, and unmapped addresses read as 0.
- R6: A disabled channel drives its output low. Writing the duty or frequency fields of a disabled channel does not make its output rise.
- R7: Changes to a running channel's registers, including clearing its enable bit, take effect only at the end of the period in progress.
- R8: When a disabled channel is enabled by a write at clock edge E, its output is still low after E and is high after edge E+1, starting a fresh period.
- R9: Reset (synchronous, active low) clears all registers and enable bits and forces every output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Write strobe, one cycle per byte written |
| reg_addr | input | ADDR_W | Register address for writes and reads |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pwm_out | output | N_CH | One PWM output per channel |

## Verification
On every cycle the assertions check several rules. The prescaler must never run past its divider. The quantum counter may only step by one or restart at zero. A channel's active settings must stay frozen between period boundaries. A newly started channel must begin with its output high, and readback must keep the unused bit positions at zero. Other behaviour can only be shown by the bench's scenarios, which measure real high and period lengths at the output. These include the exact cycle counts for different codes and duty values, the full-high case, the deferral of a disable to the end of a period, the two-edge start-up delay and the effect of reset on a running block.

// File: rtl/pwm_pkg.sv
// Package: shared widths and the per-channel configuration record.
// Assumes an 8-bit register port and the fixed 1024-quantum period.
package pwm_pkg;
    localparam int CODE_W   = 4;
    localparam int DUTY_W   = 10;
    localparam int BYTE_W   = 8;
    localparam int DIV_W    = 5;
    localparam int DIV_BASE = 32;
    localparam int QMAX     = (1 << DUTY_W) - 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [DUTY_W-1:0] duty;
        logic              en;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
// Register file: stores duty, frequency code and enable for every channel
// and returns them on a combinational read mux.
// Assumes N_CH <= 8 so the enable bits fit in one byte.
module pwm_regfile #(
    parameter int N_CH   = 3,
    parameter int ADDR_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic [pwm_pkg::BYTE_W-1:0] reg_wdata,
    output logic [pwm_pkg::BYTE_W-1:0] reg_rdata,
    output pwm_pkg::chan_cfg_t        cfg_o [N_CH]
);
    import pwm_pkg::*;

    localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(2 * N_CH);

    logic [BYTE_W-1:0] duty_lo [N_CH];
    logic [1:0]        duty_hi [N_CH];
    logic [CODE_W-1:0] code_r  [N_CH];
    logic [N_CH-1:0]   en_r;

    // Register writes: decode the address and update the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < N_CH; n++) begin
                duty_lo[n] <= '0;
                duty_hi[n] <= '0;
                code_r[n]  <= '0;
            end
            en_r <= '0;
        end else if (reg_we) begin
            for (int n = 0; n < N_CH; n++) begin
                if (reg_addr == ADDR_W'(2 * n))
                    duty_lo[n] <= reg_wdata;
                if (reg_addr == ADDR_W'(2 * n + 1)) begin
                    duty_hi[n] <= reg_wdata[1:0];
                    code_r[n]  <= reg_wdata[7:4];
                end
            end
            if (reg_addr == EN_ADDR)
                en_r <= reg_wdata[N_CH-1:0];
        end
    end

    // Read mux: stored contents, unused positions zero.
    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < N_CH; n++) begin
            if (reg_addr == ADDR_W'(2 * n))
                reg_rdata = duty_lo[n];
            if (reg_addr == ADDR_W'(2 * n + 1))
                reg_rdata = {code_r[n], 2'b00, duty_hi[n]};
        end
        if (reg_addr == EN_ADDR)
            reg_rdata = BYTE_W'(en_r);
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_cfg
        assign cfg_o[g] = '{code: code_r[g], duty: {duty_hi[g], duty_lo[g]}, en: en_r[g]};
    end

    AST_HI_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[0] && (reg_addr < EN_ADDR) && (reg_wdata[3:2] != 2'b00))
        |=> ((reg_addr != $past(reg_addr)) || (reg_rdata[3:2] == 2'b00))); // R5

    if (N_CH < BYTE_W) begin : g_en_gap
        AST_EN_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && (reg_addr == EN_ADDR) && (reg_wdata[BYTE_W-1:N_CH] != '0))
            |=> ((reg_addr != EN_ADDR) || (reg_rdata[BYTE_W-1:N_CH] == '0))); // R5
    end
endmodule

// File: rtl/pwm_prescaler.sv
// Prescaler: counts reference cycles and pulses tick on the last cycle of
// each quantum (div_m1 + 1 cycles). restart forces the count back to zero.
module pwm_prescaler #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div_m1);

    // Cycle counter within one quantum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || tick)
            cnt <= '0;
        else if (run)
            cnt <= cnt + 1'b1;
    end

    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= div_m1)); // R1
endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: holds the active settings, counts quanta across the
// 1024-quantum period and compares against the duty. New settings from the
// register file are taken only while idle or at the period's last cycle.
module pwm_chan (
    input  logic               clk,
    input  logic               rst_n,
    input  pwm_pkg::chan_cfg_t cfg_i,
    output logic               pwm_o
);
    import pwm_pkg::*;

    logic              active;
    logic [CODE_W-1:0] code_q;
    logic [DUTY_W-1:0] duty_q;
    logic [DUTY_W-1:0] qcnt;
    logic              tick;
    logic              load;
    logic [DIV_W-1:0]  div_m1;

    assign div_m1 = DIV_W'(DIV_BASE - 1) - DIV_W'(code_q);
    assign load   = !active || (tick && (qcnt == DUTY_W'(QMAX)));
    assign pwm_o  = active && (qcnt <= duty_q);

    pwm_prescaler #(.DIV_W(DIV_W)) i_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active),
        .restart (load),
        .div_m1  (div_m1),
        .tick    (tick)
    );

    // Period state: latch settings at a boundary, else advance the quantum count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            code_q <= '0;
            duty_q <= '0;
            qcnt   <= '0;
        end else if (load) begin
            active <= cfg_i.en;
            code_q <= cfg_i.code;
            duty_q <= cfg_i.duty;
            qcnt   <= '0;
        end else if (tick) begin
            qcnt <= qcnt + 1'b1;
        end
    end

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && !$past(load)) |-> ($stable(duty_q) && $stable(code_q) && active)); // R7

    AST_FRESH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> (pwm_o && (qcnt == '0))); // R8

    AST_QCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(active) && active) |->
            ((qcnt == $past(qcnt)) || (qcnt == $past(qcnt) + 1'b1) || (qcnt == '0))); // R2
endmodule

// File: rtl/pwm_multi.sv
// Top: register file plus N_CH generated channels sharing one clock.
// Assumes N_CH between 1 and 8; reg_rdata follows reg_addr combinationally.
module pwm_multi #(
    parameter int N_CH   = 3,
    parameter int ADDR_W = $clog2(2 * N_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [N_CH-1:0]   pwm_out
);
    pwm_pkg::chan_cfg_t cfg [N_CH];

    pwm_regfile #(.N_CH(N_CH), .ADDR_W(ADDR_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pwm_chan i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg_i (cfg[g]),
            .pwm_o (pwm_out[g])
        );
    end
endmodule

// File: tb/test_pwm_multi.sv
module test_pwm_multi;
    localparam int CLK_PERIOD = 10;
    localparam int N_CH = 3;
    localparam int AW   = 3;
    localparam int NV   = 6;
    // entries 0..2: first settings of channels 0..2; 3..5: second settings
    localparam int V_CODE [NV] = '{15, 14, 13, 14, 13, 15};
    localparam int V_DUTY [NV] = '{0, 511, 100, 1022, 7, 300};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [N_CH-1:0] pwm_out;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit bus_lock = 1'b0;

    pwm_multi #(.N_CH(N_CH)) i_pwm_multi (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = int'(reg_rdata);
    endtask

    task automatic set_ch(input int ch, input int code, input int duty);
        wr(2 * ch + 1, (code << 4) | (duty >> 8));
        wr(2 * ch, duty & 8'hFF);
    endtask

    task automatic wait_rise(input int ch);
        logic last;
        last = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (pwm_out[ch] && !last) break;
            last = pwm_out[ch];
        end
    endtask

    // waits for a period start, then checks high time (R1, R3) and period (R2)
    task automatic measure(input int ch, input int code, input int duty);
        int h, l, q;
        q = 32 - code;
        wait_rise(ch);
        h = 0;
        while (pwm_out[ch]) begin h++; @(negedge clk); end
        l = 0;
        while (!pwm_out[ch]) begin l++; @(negedge clk); end
        chk(h == (duty + 1) * q, "R1/R3 high time", h, (duty + 1) * q);
        chk(h + l == 1024 * q, "R2 period", h + l, 1024 * q);
    endtask

    task automatic run_ch(input int ch);
        measure(ch, V_CODE[ch], V_DUTY[ch]);
        while (bus_lock) @(negedge clk);
        bus_lock = 1'b1;
        set_ch(ch, V_CODE[ch + 3], V_DUTY[ch + 3]);
        bus_lock = 1'b0;
        // R7: the rewrite lands at the next boundary, so the next full period uses it
        measure(ch, V_CODE[ch + 3], V_DUTY[ch + 3]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int d, h;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        chk(pwm_out == '0, "R9 outputs low after reset", int'(pwm_out), 0);
        for (int a = 0; a < 8; a++) begin
            rd(a, d);
            chk(d == 0, "R9 register zero after reset", d, 0);
        end
        // R4/R5: field placement and readback
        wr(3, 8'hFF);
        rd(3, d); chk(d == 8'hF3, "R5 upper byte gap bits read zero", d, 8'hF3);
        wr(2, 8'h5A);
        rd(2, d); chk(d == 8'h5A, "R4 lower byte readback", d, 8'h5A);
        rd(7, d); chk(d == 0, "R5 unmapped address reads zero", d, 0);
        // program first settings while disabled
        for (int c = 0; c < N_CH; c++) set_ch(c, V_CODE[c], V_DUTY[c]);
        rd(3, d); chk(d == ((V_CODE[1] << 4) | (V_DUTY[1] >> 8)), "R4 upper byte fields", d,
                      (V_CODE[1] << 4) | (V_DUTY[1] >> 8));
        h = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out != '0) h++; end
        chk(h == 0, "R6 disabled channels stay low after setting writes", h, 0);
        // enable all and walk the vector table
        wr(6, 8'h07);
        for (int c = 0; c < N_CH; c++) begin
            fork
                automatic int cc = c;
                run_ch(cc);
            join_none
        end
        wait fork;
        // R3 full high and R7 deferred disable on channel 0
        wait_rise(0);
        set_ch(0, 15, 1023);
        while (pwm_out[0]) @(negedge clk);
        while (!pwm_out[0]) @(negedge clk);
        h = 0;
        while (pwm_out[0] && h < 20000) begin
            h++;
            if (h == 100) begin reg_we = 1'b1; reg_addr = AW'(6); reg_wdata = 8'h06; end
            if (h == 101) reg_we = 1'b0;
            @(negedge clk);
        end
        chk(h == 17408, "R3/R7 full-high period runs out after disable", h, 17408);
        h = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); if (pwm_out[0]) h++; end
        chk(h == 0, "R6 disabled channel low", h, 0);
        // R1 divider 32 and R8 start-up timing on channel 0
        set_ch(0, 0, 3);
        chk(pwm_out[0] == 1'b0, "R6 setting write keeps disabled output low", int'(pwm_out[0]), 0);
        wr(6, 8'hFF);
        chk(pwm_out[0] == 1'b0, "R8 low right after enable edge", int'(pwm_out[0]), 0);
        @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R8 high one edge later", int'(pwm_out[0]), 1);
        h = 0;
        while (pwm_out[0] && h < 1000) begin h++; @(negedge clk); end
        chk(h == 128, "R1 code 0 quantum is 32 cycles", h, 128);
        rd(6, d); chk(d == 8'h07, "R5 enable bits above channel count read zero", d, 8'h07);
        // R9 reset while running
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(pwm_out == '0, "R9 reset forces outputs low", int'(pwm_out), 0);
        rd(6, d); chk(d == 0, "R9 reset clears enables", d, 0);
        rd(5, d); chk(d == 0, "R9 reset clears channel settings", d, 0);
        rst_n = 1'b1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule